// File: doc/BRIEF.md
# Optical Link Monitor

This block decides whether a fiber receive path carries a usable signal. It watches two things: the sliced receive bit stream, which must keep toggling, and a level flag from an external comparator, which must report enough optical power. When both hold, the link is healthy.

Recovery from Low Light is deliberately slow. Health must first be held for a qualification time. A longer settling wait follows. The link is enabled only on a cycle in which neither the local transmit side nor the receive side is busy. Once the link is up, it is dropped only after health has been missing for twice the qualification time, so short dropouts pass unnoticed.

The block resets into Low Light. Its outputs are an enable that gates the transmit data path, the receiver and loopback, and an active-low drive for the link indicator LED. The 1 MHz idle tone is generated elsewhere and is not gated by this enable. Every duration is a parameter counted in clock cycles, so a simulation can scale them down.

Top module: `fiber_link_supervisor`

## Requirements
- R1: After reset, `link_en` is 0 and `link_led_n` is 1 (Low Light) until the recovery sequence completes.
- R2: The receive stream counts as active only while the number of sampled cycles since its last transition is below `GAP_CYCLES`. A stream whose transitions are further apart never qualifies. Health requires both `level_ok` = 1 and activity.
- R3: From Low Light, health must hold for `QUAL_CYCLES` consecutive cycles to start the settling wait. Any unhealthy cycle restarts this count.
- R4: While enabled, health must be absent for 2×`QUAL_CYCLES` consecutive cycles before the block returns to Low Light. A shorter loss has no effect on `link_en`.
- R5: After qualification, health must continue for `SETTLE_CYCLES` before any enable. A single unhealthy cycle during the wait sends the block back to Low Light, and it must qualify again.
- R6: When the wait ends, `link_en` rises only on a cycle following one where `tx_active` = 0 and `rx_active` = 0. While either is 1 the block keeps checking every cycle and enables at the first quiet one.
- R7: `link_led_n` is always the inverse of `link_en`, so 0 (LED on) means the link is enabled.
- R8: Parameter values that cannot work (`GAP_CYCLES` < 2, `QUAL_CYCLES` < 1, `SETTLE_CYCLES` < 1, `SYNC_STAGES` > 4) are rejected when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Sliced fiber receive data, asynchronous; it is synchronized inside the block |
| level_ok | input | 1 | 1 when received optical power is above threshold (the caller synchronizes it) |
| tx_active | input | 1 | 1 while the local transmit input carries data |
| rx_active | input | 1 | 1 while receive data is present |
| link_en | output | 1 | 1 enables transmit data, receiver and loopback |
| link_led_n | output | 1 | Active-low link indicator LED drive |

## Verification
Several rules are checked by assertions on every cycle:
- Each transition restarts the gap counter, and the gap counter never exceeds its limit.
- No persistence counter overflows, and each one clears when its condition drops.
- The settling state never jumps straight to enabled.
- An enable never rises after a busy cycle.
- The enable never falls without an expired loss window.

Only the bench scenarios can show the timing end to end:
- the whole recovery latency;
- that a dip shorter than the loss window is ignored;
- that transitions too far apart keep the link down;
- that one bad cycle during qualification or settling forces a full restart.

// File: rtl/flm_pkg.sv
package flm_pkg;

   // Link supervisor states; encodings are internal only.
   typedef enum logic [1:0] {
      LS_LOWLIGHT = 2'd0,
      LS_SETTLE   = 2'd1,
      LS_CHECK    = 2'd2,
      LS_PASS     = 2'd3
   } link_state_e;

endpackage

// File: rtl/flm_gap_detect.sv
// Synchronizes the receive bit, then measures the gap since its last transition.
module flm_gap_detect #(
   parameter int GAP_CYCLES  = 375,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   output logic activity_ok
);
   localparam int GW = $clog2(GAP_CYCLES + 1);
   localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYCLES);

   logic          rx_s;
   logic          rx_prev;
   logic          rx_edge;
   logic [GW-1:0] gap_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rx_bit;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= rx_bit;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign rx_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev <= 1'b0;
      end else begin
         rx_prev <= rx_s;
      end
   end

   assign rx_edge = rx_s ^ rx_prev;

   // Saturating gap counter; starts saturated so reset means "no activity".
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= GAP_LIM;
      end else if (rx_edge) begin
         gap_cnt <= '0;
      end else if (gap_cnt != GAP_LIM) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   assign activity_ok = (gap_cnt < GAP_LIM);

   p_gap_restart_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_edge |=> (gap_cnt == '0))
      else $error("R2: gap counter did not restart after a transition");

   p_gap_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= GAP_LIM)
      else $error("R2: gap counter beyond limit");

endmodule

// File: rtl/flm_persist_timer.sv
// Counts consecutive cycles of a condition; done once LIMIT cycles have been seen.
module flm_persist_timer #(
   parameter int LIMIT = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic done
);
   localparam int TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] LIM = TW'(LIMIT);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!cond) begin
         cnt <= '0;
      end else if (cnt != LIM) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign done = (cnt == LIM);

   p_no_overflow_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM)
      else $error("R3: persistence counter overflow");

   p_clear_on_break_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> (cnt == '0))
      else $error("R3: persistence counter kept count across a break");

endmodule

// File: rtl/flm_link_fsm.sv
// Supervisor state machine: Low Light -> settle -> quiet check -> Pass.
module flm_link_fsm
   import flm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        healthy,
   input  logic        qual_done,
   input  logic        settle_done,
   input  logic        loss_done,
   input  logic        tx_active,
   input  logic        rx_active,
   output link_state_e state
);
   link_state_e state_nx;
   logic        quiet;

   assign quiet = !tx_active && !rx_active;

   always_comb begin
      state_nx = state;
      unique case (state)
         LS_LOWLIGHT: if (qual_done) state_nx = LS_SETTLE;
         LS_SETTLE: begin
            if (!healthy)         state_nx = LS_LOWLIGHT;
            else if (settle_done) state_nx = LS_CHECK;
         end
         LS_CHECK: begin
            if (!healthy)   state_nx = LS_LOWLIGHT;
            else if (quiet) state_nx = LS_PASS;
         end
         LS_PASS: if (loss_done) state_nx = LS_LOWLIGHT;
         default: state_nx = LS_LOWLIGHT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LS_LOWLIGHT;
      end else begin
         state <= state_nx;
      end
   end

   p_settle_no_jump_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_SETTLE) |=> (state != LS_PASS))
      else $error("R5: settle state jumped straight to Pass");

   p_lowlight_exit_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (state == LS_LOWLIGHT && !qual_done) |=> (state == LS_LOWLIGHT))
      else $error("R3: left Low Light without qualification");

endmodule

// File: rtl/fiber_link_supervisor.sv
module fiber_link_supervisor
   import flm_pkg::*;
#(
   parameter int GAP_CYCLES    = 375,
   parameter int QUAL_CYCLES   = 250,
   parameter int SETTLE_CYCLES = 62_500_000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic level_ok,
   input  logic tx_active,
   input  logic rx_active,
   output logic link_en,
   output logic link_led_n
);
   localparam int LOSS_CYCLES = 2 * QUAL_CYCLES;

   // R8: elaboration-time parameter checks
   generate
      if (GAP_CYCLES < 2) begin : g_bad_gap
         $error("R8: GAP_CYCLES must be at least 2");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("R8: QUAL_CYCLES must be at least 1");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("R8: SETTLE_CYCLES must be at least 1");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("R8: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   link_state_e state;
   logic activity_ok;
   logic healthy;
   logic qual_done, settle_done, loss_done;

   flm_gap_detect #(
      .GAP_CYCLES (GAP_CYCLES),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_gap (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_bit     (rx_bit),
      .activity_ok(activity_ok)
   );

   assign healthy = level_ok && activity_ok;

   flm_persist_timer #(.LIMIT(QUAL_CYCLES)) u_qual (
      .clk  (clk),
      .rst_n(rst_n),
      .cond ((state == LS_LOWLIGHT) && healthy),
      .done (qual_done)
   );

   flm_persist_timer #(.LIMIT(SETTLE_CYCLES)) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .cond ((state == LS_SETTLE) && healthy),
      .done (settle_done)
   );

   flm_persist_timer #(.LIMIT(LOSS_CYCLES)) u_loss (
      .clk  (clk),
      .rst_n(rst_n),
      .cond ((state == LS_PASS) && !healthy),
      .done (loss_done)
   );

   flm_link_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .healthy    (healthy),
      .qual_done  (qual_done),
      .settle_done(settle_done),
      .loss_done  (loss_done),
      .tx_active  (tx_active),
      .rx_active  (rx_active),
      .state      (state)
   );

   assign link_en    = (state == LS_PASS);
   assign link_led_n = !link_en;

   p_enable_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> $past(!tx_active && !rx_active))
      else $error("R6: link enabled after a busy cycle");

   p_drop_needs_loss_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_en) |-> $past(loss_done))
      else $error("R4: link dropped without a full loss window");

endmodule

// File: tb/fiber_link_supervisor_bench.sv
module fiber_link_supervisor_bench;
   localparam int GAP    = 8;
   localparam int QUAL   = 10;
   localparam int LOSS   = 2 * QUAL;
   localparam int SETTLE = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0;
   logic level_ok = 1'b0;
   logic tx_active = 1'b0;
   logic rx_active = 1'b0;
   logic link_en, link_led_n;

   int checks = 0;
   int fails = 0;
   bit tog_on = 1'b0;
   int tog_period = 2;

   always #4 clk = ~clk;  // 125 MHz

   fiber_link_supervisor #(
      .GAP_CYCLES(GAP), .QUAL_CYCLES(QUAL), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)
   ) u_fiber_link_supervisor (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .level_ok(level_ok),
      .tx_active(tx_active), .rx_active(rx_active),
      .link_en(link_en), .link_led_n(link_led_n)
   );

   // Receive-stream toggler: one transition every tog_period cycles.
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (tog_on) begin
            if (cnt >= tog_period - 1) begin
               rx_bit <= ~rx_bit;
               cnt = 0;
            end else begin
               cnt++;
            end
         end else begin
            cnt = 0;
         end
      end
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   // Counts cycles until link_en equals target (or limit).
   task automatic wait_en(input bit target, input int limit, output int n);
      n = 0;
      while (link_en !== target && n < limit) begin
         @(posedge clk);
         #1;
         n++;
      end
   endtask

   task automatic bring_up();
      int n;
      @(negedge clk);
      tx_active = 0; rx_active = 0; level_ok = 1; tog_period = 2; tog_on = 1;
      wait_en(1'b1, 300, n);
   endtask

   task automatic go_down();
      int n;
      @(negedge clk);
      level_ok = 0;
      wait_en(1'b0, 300, n);
   endtask

   task automatic t_reset();
      rst_n = 0;
      cycles(3);
      check(link_en == 0, "R1", "link_en in reset", link_en, 0);
      check(link_led_n == 1, "R1", "link_led_n in reset", link_led_n, 1);
      @(negedge clk);
      rst_n = 1;
      cycles(5);
      check(link_en == 0, "R1", "link_en after reset, no signal", link_en, 0);
   endtask

   task automatic t_bringup();
      int n;
      @(negedge clk);
      level_ok = 1; tog_period = 2; tog_on = 1;
      wait_en(1'b1, 300, n);
      check(n >= QUAL + SETTLE && n <= QUAL + SETTLE + 14, "R5",
            "bring-up latency", n, QUAL + SETTLE + 5);
      check(link_led_n == 0, "R7", "LED on when enabled", link_led_n, 0);
   endtask

   task automatic t_short_dip();
      @(negedge clk);
      level_ok = 0;
      cycles(LOSS - 5);
      check(link_en == 1, "R4", "link during short dip", link_en, 1);
      @(negedge clk);
      level_ok = 1;
      cycles(LOSS + 5);
      check(link_en == 1, "R4", "link after short dip", link_en, 1);
   endtask

   task automatic t_level_loss();
      int n;
      @(negedge clk);
      level_ok = 0;
      wait_en(1'b0, 300, n);
      check(n >= LOSS && n <= LOSS + 3, "R4", "level loss latency", n, LOSS + 1);
      check(link_led_n == 1, "R7", "LED off after loss", link_led_n, 1);
   endtask

   task automatic t_activity_loss();
      int n;
      bring_up();
      @(negedge clk);
      tog_on = 0;
      wait_en(1'b0, 300, n);
      check(n >= GAP + LOSS - 2 && n <= GAP + LOSS + 8, "R2",
            "activity loss latency", n, GAP + LOSS + 3);
   endtask

   task automatic t_gap_edges();
      // Transitions just inside the gap limit keep the link up.
      bring_up();
      @(negedge clk);
      tog_period = GAP - 3;
      cycles(100);
      check(link_en == 1, "R2", "link with gaps below limit", link_en, 1);
      go_down();
      // Transitions too far apart never qualify.
      @(negedge clk);
      tog_period = GAP + 4; level_ok = 1;
      cycles(QUAL + SETTLE + 60);
      check(link_en == 0, "R2", "link with gaps above limit", link_en, 0);
      @(negedge clk);
      tog_period = 2;
   endtask

   task automatic t_busy_line();
      int n;
      go_down();
      @(negedge clk);
      tx_active = 1; rx_active = 1; level_ok = 1; tog_period = 2; tog_on = 1;
      cycles(QUAL + SETTLE + 20);
      check(link_en == 0, "R6", "held off while both busy", link_en, 0);
      @(negedge clk);
      tx_active = 0;
      cycles(10);
      check(link_en == 0, "R6", "held off while receive busy", link_en, 0);
      @(negedge clk);
      rx_active = 0;
      wait_en(1'b1, 20, n);
      check(n >= 1 && n <= 2, "R6", "enable at first quiet cycle", n, 1);
   endtask

   task automatic t_requal();
      int n;
      go_down();
      @(negedge clk);
      level_ok = 1;
      cycles(QUAL - 2);
      @(negedge clk);
      level_ok = 0;
      @(negedge clk);
      level_ok = 1;
      wait_en(1'b1, 300, n);
      check(n >= QUAL + SETTLE && n <= QUAL + SETTLE + 6, "R3",
            "qualification restarted after break", n, QUAL + SETTLE + 2);
   endtask

   task automatic t_settle_break();
      int n;
      go_down();
      @(negedge clk);
      level_ok = 1;
      cycles(QUAL + 15);
      @(negedge clk);
      level_ok = 0;
      @(negedge clk);
      level_ok = 1;
      wait_en(1'b1, 300, n);
      check(n >= QUAL + SETTLE && n <= QUAL + SETTLE + 6, "R5",
            "full requalification after settle break", n, QUAL + SETTLE + 2);
      check(link_led_n == !link_en, "R7", "LED tracks enable", link_led_n, !link_en);
   endtask

   initial begin
      t_reset();
      t_bringup();
      t_short_dip();
      t_level_loss();
      t_activity_loss();
      t_gap_edges();
      t_busy_line();
      t_requal();
      t_settle_break();
      report();
      $finish;
   end

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end
endmodule